// File: doc/BRIEF.md
# Overflow-Guarded Capture Buffer

This block sits between a free-running sample source and a host read port that share one clock. Each sample the source offers is pushed into a 512-word, 32-bit first-in first-out buffer while capture is enabled. The host drains the buffer through a read port with a read strobe, registered data, an empty flag and an end-of-stream flag.

The block remembers whether the buffer has ever filled up after it was first seen with room in it. That sticky condition stops capture for good. Once the host has drained every word captured before the stop, the block raises end-of-stream. The host can therefore treat an unbroken stream as lossless: if anything had been dropped, the stream would have ended instead.

The whole block is cleared by a synchronous reset that is active while neither of the host's channel-open indications is high.

Top module: `ovf_capture_fifo`

## Requirements
- R1: On any clock edge where `host_wr_open` and `host_rd_open` are both low, the block resets: afterwards `rd_empty`=1, `rd_eof`=0, `rd_data`=0, the buffer holds no words and both sticky flags are clear. If either indication is high, the contents are kept.
- R2: A sample on `src_data` is stored when `src_valid`=1, capture is enabled and the buffer is not full. Words are read out in the order they were stored.
- R3: `rd_en`=1 on an edge where `rd_empty`=0 removes the oldest word and presents it on `rd_data` after that edge. `rd_en` while `rd_empty`=1 is ignored, and `rd_data` keeps its value.
- R4: The buffer holds exactly 512 words. A sample offered while it is full is dropped.
- R5: A "has had room" flag is set on the first edge after reset at which the buffer is not full. The overflow flag is set on an edge at which the buffer is full and the "has had room" flag is already set.
- R6: The overflow flag is sticky until reset. While it is set, no sample is stored, whatever `src_valid` does.
- R7: `rd_eof` equals `rd_empty` AND the overflow flag. It is a level and stays high for as long as both hold.
- R8: `rd_eof` rises only on a cycle that follows a cycle with `rd_en`=1, or that follows a cycle with `rd_empty`=1.
- R9: After a reset that follows an overflow, capture resumes and `rd_eof` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| host_wr_open | input | 1 | Host write channel open; the block resets when this and host_rd_open are both low |
| host_rd_open | input | 1 | Host read channel open |
| src_valid | input | 1 | Source sample strobe |
| src_data | input | 32 | Source sample |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 32 | Word read out, registered |
| rd_empty | output | 1 | Buffer holds no words |
| rd_eof | output | 1 | End of stream after an overflow |

## Verification
The assertions check on every cycle:
- the rising-edge rule for `rd_eof`;
- that `rd_eof` never stands without `rd_empty`;
- the stickiness of overflow and that no write happens after it;
- that overflow is only ever preceded by the "has had room" flag and a full buffer;
- the fill-level bound and the reset clearing.

Only the bench scenarios can show the rest:
- that the words come out in capture order;
- that the depth is exactly 512;
- that samples offered during the drain never appear;
- that a single open indication keeps the contents;
- that capture restarts after a reset.

// File: rtl/capgate_pkg.sv
package capgate_pkg;

  localparam int DATA_W_DEF = 32;
  localparam int DEPTH_DEF  = 512;

  // next position of a circular pointer over a storage of `depth` words
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // stream end is visible only once the buffer is drained after an overflow
  function automatic logic eof_level(input logic empty, input logic overflow);
    return empty & overflow;
  endfunction

  // a sample is accepted only if capture is allowed and there is room
  function automatic logic accept(input logic enable, input logic valid, input logic full);
    return enable & valid & ~full;
  endfunction

endpackage

// File: rtl/capgate_store.sv
module capgate_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_fire,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  assign empty   = (level == '0);
  assign full    = (level == CNT_W'(DEPTH));
  assign rd_fire = rd_req & ~empty;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_fire) wr_ptr <= PTR_W'(capgate_pkg::ptr_next(int'(wr_ptr), DEPTH));
      if (rd_fire) begin
        rd_ptr  <= PTR_W'(capgate_pkg::ptr_next(int'(rd_ptr), DEPTH));
        rd_data <= mem[rd_ptr];
      end
      case ({wr_fire, rd_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/capgate_guard.sv
module capgate_guard (
  input  logic clk,
  input  logic srst,
  input  logic full,
  output logic nonfull_seen,
  output logic ovf_flag,
  output logic cap_en
);

  always_ff @(posedge clk) begin
    if (srst) begin
      nonfull_seen <= 1'b0;
      ovf_flag     <= 1'b0;
    end else begin
      if (!full) nonfull_seen <= 1'b1;
      if (full && nonfull_seen) ovf_flag <= 1'b1;
    end
  end

  assign cap_en = ~ovf_flag;

endmodule

// File: rtl/ovf_capture_fifo.sv
module ovf_capture_fifo #(
  parameter int DATA_W = capgate_pkg::DATA_W_DEF,
  parameter int DEPTH  = capgate_pkg::DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              host_wr_open,
  input  logic              host_rd_open,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_eof
);

  // named internal events, observed by the bound checker
  logic             srst;
  logic             wr_fire;
  logic             rd_fire;
  logic             fifo_full;
  logic [CNT_W-1:0] fifo_level;
  logic             nonfull_seen;
  logic             ovf_flag;
  logic             cap_en;

  assign srst    = ~host_wr_open & ~host_rd_open;
  assign wr_fire = capgate_pkg::accept(cap_en, src_valid, fifo_full);

  capgate_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .srst    (srst),
    .wr_fire (wr_fire),
    .wr_data (src_data),
    .rd_req  (rd_en),
    .rd_fire (rd_fire),
    .rd_data (rd_data),
    .empty   (rd_empty),
    .full    (fifo_full),
    .level   (fifo_level)
  );

  capgate_guard u_guard (
    .clk          (clk),
    .srst         (srst),
    .full         (fifo_full),
    .nonfull_seen (nonfull_seen),
    .ovf_flag     (ovf_flag),
    .cap_en       (cap_en)
  );

  assign rd_eof = capgate_pkg::eof_level(rd_empty, ovf_flag);

endmodule

// File: rtl/ovf_capture_fifo_chk.sv
module ovf_capture_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              srst,
  input logic              rd_en,
  input logic              rd_empty,
  input logic              rd_eof,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_fire,
  input logic              fifo_full,
  input logic [CNT_W-1:0]  fifo_level,
  input logic              nonfull_seen,
  input logic              ovf_flag
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    srst |=> (fifo_level == '0 && !ovf_flag && !nonfull_seen && rd_data == '0));

  // R3
  a_r3_empty_read_ignored: assert property (@(posedge clk) disable iff (srst)
    (rd_en && rd_empty) |=> $stable(rd_data));

  // R4
  a_r4_level_bound: assert property (@(posedge clk) disable iff (srst)
    fifo_level <= CNT_W'(DEPTH));

  // R5
  a_r5_ovf_needs_room_first: assert property (@(posedge clk) disable iff (srst)
    $rose(ovf_flag) |-> ($past(fifo_full) && $past(nonfull_seen)));

  // R6
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (srst)
    ovf_flag |=> ovf_flag);

  // R6
  a_r6_no_capture: assert property (@(posedge clk) disable iff (srst)
    ovf_flag |-> !wr_fire);

  // R7
  a_r7_eof_only_when_empty: assert property (@(posedge clk) disable iff (srst)
    rd_eof |-> rd_empty);

  // R8
  a_r8_eof_rise_rule: assert property (@(posedge clk) disable iff (srst)
    $rose(rd_eof) |-> ($past(rd_en) || $past(rd_empty)));

endmodule

bind ovf_capture_fifo ovf_capture_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .srst         (srst),
  .rd_en        (rd_en),
  .rd_empty     (rd_empty),
  .rd_eof       (rd_eof),
  .rd_data      (rd_data),
  .wr_fire      (wr_fire),
  .fifo_full    (fifo_full),
  .fifo_level   (fifo_level),
  .nonfull_seen (nonfull_seen),
  .ovf_flag     (ovf_flag)
);

// File: tb/ovf_capture_fifo_bench.sv
module ovf_capture_fifo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int DEPTH      = 512;

  logic              clk = 1'b0;
  logic              host_wr_open = 1'b0;
  logic              host_rd_open = 1'b0;
  logic              src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_empty;
  logic              rd_eof;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovf_capture_fifo u_ovf_capture_fifo (
    .clk          (clk),
    .host_wr_open (host_wr_open),
    .host_rd_open (host_rd_open),
    .src_valid    (src_valid),
    .src_data     (src_data),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .rd_empty     (rd_empty),
    .rd_eof       (rd_eof)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit chk_on   = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected-value functions, written from the requirements
  function automatic bit m_eof(input int words, input bit ovf);
    return (words == 0) && ovf;
  endfunction

  function automatic bit m_take(input bit ovf, input bit valid, input int words);
    return !ovf && valid && (words < DEPTH);
  endfunction

  // reference state
  logic [DATA_W-1:0] mq[$];
  logic [DATA_W-1:0] m_last = '0;
  bit m_ovf = 1'b0;
  bit m_room = 1'b0;

  always @(posedge clk) begin : model
    bit full_now;
    bit take_now;
    bit pop_now;
    if (!host_wr_open && !host_rd_open) begin
      mq.delete();
      m_ovf  = 1'b0;
      m_room = 1'b0;
      m_last = '0;
    end else begin
      full_now = (mq.size() == DEPTH);
      take_now = m_take(m_ovf, src_valid, mq.size());
      pop_now  = rd_en && (mq.size() != 0);
      if (full_now && m_room) m_ovf = 1'b1;
      if (!full_now) m_room = 1'b1;
      if (pop_now) m_last = mq.pop_front();
      if (take_now) mq.push_back(src_data);
    end
  end

  // per-cycle comparison, away from the active edge
  bit prev_rden  = 1'b0;
  bit prev_empty = 1'b1;
  bit prev_eof   = 1'b0;

  always @(negedge clk) begin
    if (chk_on) begin
      check(rd_empty == (mq.size() == 0), "R2 empty flag", 32'(rd_empty), 32'(mq.size() == 0));
      check(rd_data == m_last, "R2/R3 read data order", rd_data, m_last);
      check(rd_eof == m_eof(mq.size(), m_ovf), "R7 eof level", 32'(rd_eof), 32'(m_eof(mq.size(), m_ovf)));
      if (rd_eof && !prev_eof)
        check(prev_rden || prev_empty, "R8 eof rise after read or empty", 32'(prev_rden), 32'd1);
    end
    prev_rden  = rd_en;
    prev_empty = rd_empty;
    prev_eof   = rd_eof;
  end

  task automatic drive(input bit v, input bit r);
    @(posedge clk);
    #1;
    src_valid = v;
    src_data  = $urandom;
    rd_en     = r;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int reads;
    void'($urandom(32'd20240611));
    repeat (3) drive(1'b1, 1'b0);
    chk_on = 1'b1;
    check(rd_empty == 1'b1, "R1 empty after reset", 32'(rd_empty), 32'd1);
    check(rd_eof == 1'b0, "R1 eof low after reset", 32'(rd_eof), 32'd0);
    check(rd_data == '0, "R1 data cleared", rd_data, 32'd0);
    host_wr_open = 1'b1;
    host_rd_open = 1'b1;

    // R2 R3 R5: random traffic, reads outpace writes so no overflow
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 100) < 55, ($urandom % 100) < 75);
    check(rd_eof == 1'b0, "R5 no overflow in light traffic", 32'(rd_eof), 32'd0);

    // R1: one open indication alone keeps contents
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0);
    host_wr_open = 1'b0;
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
    check(rd_empty == 1'b0, "R1 contents kept with read side open", 32'(rd_empty), 32'd0);
    host_wr_open = 1'b1;

    // R3: drain, then read strobes on an empty buffer
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b1);
    check(rd_empty == 1'b1, "R3 drained", 32'(rd_empty), 32'd1);
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1);
    check(rd_data == m_last, "R3 read on empty ignored", rd_data, m_last);

    // R4 R5 R6: fill past capacity with no reads
    for (int i = 0; i < DEPTH + 80; i++) drive(1'b1, 1'b0);
    check(rd_eof == 1'b0, "R7 eof low while data remains", 32'(rd_eof), 32'd0);

    // R4 R6: drain with the source still active, count words
    reads = 0;
    for (int i = 0; i < DEPTH + 40; i++) begin
      drive(($urandom % 2) == 1, 1'b1);
      @(negedge clk);
      if (!prev_empty && prev_rden) reads++;
    end
    check(reads == DEPTH, "R4 exactly depth words before stream end", 32'(reads), 32'(DEPTH));
    check(rd_eof == 1'b1, "R7 eof after drain", 32'(rd_eof), 32'd1);

    // R6 R7: source keeps offering, nothing stored, eof holds
    for (int i = 0; i < 30; i++) drive(1'b1, ($urandom % 2) == 1);
    check(rd_empty == 1'b1, "R6 no capture after overflow", 32'(rd_empty), 32'd1);
    check(rd_eof == 1'b1, "R7 eof stays high", 32'(rd_eof), 32'd1);

    // R9: full reset, capture resumes
    host_wr_open = 1'b0;
    host_rd_open = 1'b0;
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    check(rd_eof == 1'b0, "R9 eof cleared by reset", 32'(rd_eof), 32'd0);
    host_wr_open = 1'b1;
    host_rd_open = 1'b1;
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check(rd_empty == 1'b0, "R9 capture resumes", 32'(rd_empty), 32'd0);
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1);
    check(rd_eof == 1'b0, "R9 no eof after clean drain", 32'(rd_eof), 32'd0);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule